// File: doc/BRIEF.md
# DDR2 Mode Register Command Decoder

This block sits on the device side of a DDR2-style SDRAM model. On every rising clock edge it samples the command bus. It picks out mode register write commands and decides whether each write may take effect. A write takes effect only when the device is in a safe state: every bank is closed and the clock enable is high. The write must also come outside the quiet window that follows the previous accepted write.

An accepted write goes to one of four 13-bit registers, chosen by the two low bank address bits. The main register is decoded into the operating parameters that the rest of the model uses: burst length, burst ordering, read latency, write recovery, test mode and power-down exit speed. A DLL reset request is turned into a single-cycle pulse. Codes that no setting defines are flagged. The three extended registers are kept as raw values.

Rejected commands leave every register as it was. Each rejection raises a one-cycle error pulse that names its cause.

Top module: `ddr2_mode_regs`

## Requirements
- R1: A write command is `cs_n`, `ras_n`, `cas_n` and `we_n` all low at a rising edge. When accepted, it stores `addr[12:0]` into the register chosen by `ba[1:0]`: 0 is the main register, 1 is extended register 1, 2 is extended register 2 and 3 is extended register 3. The other registers keep their values.
- R2: A write command with `ba[2]` = 1 changes no register. One cycle later it raises `bank_err` for exactly one cycle.
- R3: A write command given while `banks_idle` is low or `cke` is low changes no register. One cycle later it raises `illegal_err` for exactly one cycle.
- R4: Any command (`cs_n` low and not all of `ras_n`, `cas_n`, `we_n` high) in the TMRD-1 cycles after an accepted write raises `tmrd_viol` for one cycle, one cycle later. A write inside that window changes no register. A command exactly TMRD cycles after the write is not a violation.
- R5: `burst_len` is 4 when main register bits [2:0] are 010, 8 when they are 011, and 0 (reserved) for every other code.
- R6: `burst_interleave` equals main register bit 3: 1 is interleaved, 0 is sequential.
- R7: `cas_lat` equals main register bits [6:4] when those bits are 3 to 7. For codes 0 to 2 it is 0 (reserved).
- R8: `wr_cycles` is main register bits [11:9] plus 1 for codes 1 to 7, giving 2 to 8. Code 0 gives 0 (reserved).
- R9: `test_mode` follows main register bit 7. `slow_pd_exit` follows main register bit 12.
- R10: An accepted main-register write with `addr[8]` = 1 makes `dll_reset` high for exactly the one cycle after the write edge.
- R11: After reset, `mr_valid`, all registers, all flags and all decoded outputs are 0. `mr_valid` goes high with the first accepted main-register write and stays high until the next reset.
- R12: `reserved_code` is high exactly when `mr_valid` is high and the stored main register holds a reserved burst length, read latency or write recovery code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable from the command bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address; [1:0] chooses the register, [2] must be 0 |
| addr | input | 13 | Address bus carrying the register value |
| banks_idle | input | 1 | High while every bank is precharged |
| mr_valid | output | 1 | Main register has been written since reset |
| burst_len | output | 4 | Burst length 4 or 8; 0 when reserved |
| burst_interleave | output | 1 | 1 for interleaved order, 0 for sequential |
| cas_lat | output | 3 | Read latency 3 to 7; 0 when reserved |
| wr_cycles | output | 4 | Write recovery 2 to 8; 0 when reserved |
| test_mode | output | 1 | Test mode bit of the main register |
| slow_pd_exit | output | 1 | 1 selects slow power-down exit |
| dll_reset | output | 1 | One-cycle DLL reset request |
| reserved_code | output | 1 | Stored main register holds a reserved code |
| emr1_val | output | 13 | Raw extended register 1 |
| emr2_val | output | 13 | Raw extended register 2 |
| emr3_val | output | 13 | Raw extended register 3 |
| bank_err | output | 1 | Write rejected because `ba[2]` was set |
| illegal_err | output | 1 | Write rejected for open banks or low clock enable |
| tmrd_viol | output | 1 | Command seen inside the post-write quiet window |

## Verification
Every one of the 8192 main-register values is written in turn. Each field decode is then compared one cycle after the write edge, so a wrong bit slice or a wrong reserved test shows up at the very next sample for the code concerned. A gap counter that is loaded with the wrong value, or that never clears, shows up as a missing or spurious `tmrd_viol`. It also shows up as an extended register that changes when it should not, both on the cycle after the offending command. A broken acceptance gate lets a rejected write reach a register, and the readback two cycles after the command shows the wrong value.

// File: rtl/ddr2_mode_regs.sv
`timescale 1ns/1ps
module ddr2_mode_regs #(
  parameter int TMRD = 2,
  parameter int AW   = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic          cs_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [2:0]    ba,
  input  logic [AW-1:0] addr,
  input  logic          banks_idle,
  output logic          mr_valid,
  output logic [3:0]    burst_len,
  output logic          burst_interleave,
  output logic [2:0]    cas_lat,
  output logic [3:0]    wr_cycles,
  output logic          test_mode,
  output logic          slow_pd_exit,
  output logic          dll_reset,
  output logic          reserved_code,
  output logic [AW-1:0] emr1_val,
  output logic [AW-1:0] emr2_val,
  output logic [AW-1:0] emr3_val,
  output logic          bank_err,
  output logic          illegal_err,
  output logic          tmrd_viol
);
  localparam int GW = (TMRD > 1) ? $clog2(TMRD) : 1;
  localparam logic [GW-1:0] GAP_LOAD = GW'(TMRD - 1);

  logic [AW-1:0] mr_q;
  logic [GW-1:0] gap;

  wire is_mrs  = !cs_n && !ras_n && !cas_n && !we_n;
  wire cmd_any = !cs_n && !(ras_n && cas_n && we_n);
  wire in_gap  = gap != '0;
  wire accept  = is_mrs && !ba[2] && cke && banks_idle && !in_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_q        <= '0;
      emr1_val    <= '0;
      emr2_val    <= '0;
      emr3_val    <= '0;
      mr_valid    <= 1'b0;
      gap         <= '0;
      dll_reset   <= 1'b0;
      bank_err    <= 1'b0;
      illegal_err <= 1'b0;
      tmrd_viol   <= 1'b0;
    end else begin
      bank_err    <= is_mrs && ba[2];
      illegal_err <= is_mrs && (!cke || !banks_idle);
      tmrd_viol   <= cmd_any && in_gap;
      dll_reset   <= accept && ba[1:0] == 2'd0 && addr[8];
      if (accept) gap <= GAP_LOAD;
      else if (in_gap) gap <= gap - 1'b1;
      if (accept) begin
        case (ba[1:0])
          2'd0: begin mr_q <= addr; mr_valid <= 1'b1; end
          2'd1: emr1_val <= addr;
          2'd2: emr2_val <= addr;
          default: emr3_val <= addr;
        endcase
      end
    end
  end

  wire [2:0] bl_code = mr_q[2:0];
  wire [2:0] cl_code = mr_q[6:4];
  wire [2:0] wr_code = mr_q[11:9];

  assign burst_len        = (bl_code == 3'b010) ? 4'd4 : (bl_code == 3'b011) ? 4'd8 : 4'd0;
  assign burst_interleave = mr_q[3];
  assign cas_lat          = (cl_code >= 3'd3) ? cl_code : 3'd0;
  assign wr_cycles        = (wr_code != 3'd0) ? {1'b0, wr_code} + 4'd1 : 4'd0;
  assign test_mode        = mr_q[7];
  assign slow_pd_exit     = mr_q[12];
  assign reserved_code    = mr_valid && (burst_len == 4'd0 || cas_lat == 3'd0 || wr_cycles == 4'd0);

  p_bank_nostore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_err |-> $stable(mr_q) && $stable(emr1_val) && $stable(emr2_val) && $stable(emr3_val));
  p_illegal_nostore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_err |-> $stable(mr_q) && $stable(emr1_val) && $stable(emr2_val) && $stable(emr3_val));
  p_gap_nostore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tmrd_viol |-> $stable(mr_q) && $stable(emr1_val) && $stable(emr2_val) && $stable(emr3_val));
  p_bl_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_len == 4'd0 || burst_len == 4'd4 || burst_len == 4'd8);
  p_dll_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset |-> mr_valid && $past(!cs_n));
  p_valid_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mr_valid |=> mr_valid);
  p_rsv_needs_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !mr_valid |-> !reserved_code);
endmodule

// File: tb/ddr2_mode_regs_test.sv
`timescale 1ns/1ps
module ddr2_mode_regs_test;
  logic clk = 0, rst_n = 0, cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, banks_idle = 1;
  logic [2:0] ba = 0;
  logic [12:0] addr = 0;
  logic mr_valid, burst_interleave, test_mode, slow_pd_exit, dll_reset, reserved_code;
  logic bank_err, illegal_err, tmrd_viol;
  logic [3:0] burst_len, wr_cycles;
  logic [2:0] cas_lat;
  logic [12:0] emr1_val, emr2_val, emr3_val;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ddr2_mode_regs uut (.clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .banks_idle(banks_idle),
    .mr_valid(mr_valid), .burst_len(burst_len), .burst_interleave(burst_interleave),
    .cas_lat(cas_lat), .wr_cycles(wr_cycles), .test_mode(test_mode),
    .slow_pd_exit(slow_pd_exit), .dll_reset(dll_reset), .reserved_code(reserved_code),
    .emr1_val(emr1_val), .emr2_val(emr2_val), .emr3_val(emr3_val),
    .bank_err(bank_err), .illegal_err(illegal_err), .tmrd_viol(tmrd_viol));

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic drive_nop();
    cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
  endtask

  task automatic drive_mrs(input logic [2:0] b, input logic [12:0] a);
    cs_n = 0; ras_n = 0; cas_n = 0; we_n = 0; ba = b; addr = a;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 valid after reset", mr_valid, 0);
    chk("R11 bl after reset", burst_len, 0);
    chk("R11 emr1 after reset", emr1_val, 0);
    chk("R12 rsv after reset", reserved_code, 0);

    banks_idle = 0; drive_mrs(3'd0, 13'h0632);
    @(negedge clk); drive_nop(); banks_idle = 1;
    chk("R3 open banks flag", illegal_err, 1);
    chk("R3 open banks no store", mr_valid, 0);
    @(negedge clk);
    chk("R3 flag one cycle", illegal_err, 0);
    cke = 0; drive_mrs(3'd1, 13'h0123);
    @(negedge clk); drive_nop(); cke = 1;
    chk("R3 cke low flag", illegal_err, 1);
    @(negedge clk);
    chk("R3 cke low no store", emr1_val, 0);
    drive_mrs(3'd4, 13'h0632);
    @(negedge clk); drive_nop();
    chk("R2 bank flag", bank_err, 1);
    chk("R2 no store", mr_valid, 0);
    @(negedge clk);
    chk("R2 flag one cycle", bank_err, 0);

    for (int a = 0; a < 8192; a++) begin
      chk("R10 dll low between", dll_reset, 0);
      drive_mrs(3'd0, 13'(a));
      @(negedge clk); drive_nop();
      begin
        int bl, cl, wr, rsv;
        bl = (a[2:0] == 3'b010) ? 4 : (a[2:0] == 3'b011) ? 8 : 0;
        cl = (a[6:4] >= 3) ? int'(a[6:4]) : 0;
        wr = (a[11:9] != 0) ? int'(a[11:9]) + 1 : 0;
        rsv = (bl == 0 || cl == 0 || wr == 0) ? 1 : 0;
        chk("R1 R11 valid", mr_valid, 1);
        chk("R5 burst length", burst_len, bl);
        chk("R6 burst type", burst_interleave, a[3]);
        chk("R7 cas latency", cas_lat, cl);
        chk("R8 write recovery", wr_cycles, wr);
        chk("R9 test mode", test_mode, a[7]);
        chk("R9 pd exit", slow_pd_exit, a[12]);
        chk("R10 dll pulse", dll_reset, a[8]);
        chk("R12 reserved", reserved_code, rsv);
        chk("R4 no viol at gap", tmrd_viol, 0);
      end
      @(negedge clk);
    end

    drive_mrs(3'd0, 13'h0632); @(negedge clk); drive_nop(); @(negedge clk);
    drive_mrs(3'd1, 13'h0AAA); @(negedge clk); drive_nop(); @(negedge clk);
    drive_mrs(3'd2, 13'h1555); @(negedge clk); drive_nop(); @(negedge clk);
    drive_mrs(3'd3, 13'h0F0F); @(negedge clk); drive_nop(); @(negedge clk);
    chk("R1 emr1", emr1_val, 13'h0AAA);
    chk("R1 emr2", emr2_val, 13'h1555);
    chk("R1 emr3", emr3_val, 13'h0F0F);
    chk("R1 mr kept", burst_len, 4);
    chk("R1 mr kept cl", cas_lat, 3);

    drive_mrs(3'd1, 13'h0111);
    @(negedge clk); drive_mrs(3'd2, 13'h0222);
    @(negedge clk); drive_nop();
    chk("R4 viol on mrs", tmrd_viol, 1);
    chk("R4 emr2 kept", emr2_val, 13'h1555);
    chk("R1 emr1 taken", emr1_val, 13'h0111);
    @(negedge clk);
    chk("R4 viol one cycle", tmrd_viol, 0);
    drive_mrs(3'd3, 13'h0333);
    @(negedge clk); cs_n = 0; ras_n = 0; cas_n = 1; we_n = 1;
    @(negedge clk); drive_nop();
    chk("R4 viol on activate", tmrd_viol, 1);
    chk("R1 emr3 taken", emr3_val, 13'h0333);
    @(negedge clk); drive_mrs(3'd2, 13'h0444);
    @(negedge clk); drive_nop();
    chk("R4 boundary ok", tmrd_viol, 0);
    chk("R4 boundary stored", emr2_val, 13'h0444);

    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R11 valid cleared", mr_valid, 0);
    chk("R11 emr3 cleared", emr3_val, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule